// File: doc/BRIEF.md
# Bypassed Three-Stage Bitwise ALU Pipeline

This block is a small synchronous datapath with three stages: operand fetch, execute and write-back. Each clock cycle it accepts one instruction made of two source register addresses, a destination register address, a one-bit operation code and a stall flag. The two operands are latched from a register file of 2^AW entries, D bits wide. The execute stage combines them bit by bit with OR or NOR. The result register holds the outcome, and the write-back stage stores it in the destination entry.

The stall flag, the destination address and the operation code move down the pipeline alongside the data. A stalled instruction does not change the result register or the register file. Read-after-write hazards are resolved by forwarding. The operand latches take the live ALU output from the instruction in execute. If that does not apply, they take the result register from the instruction in write-back. Otherwise they read the register file. The newer producer always wins. As a result, a program sees plain in-order register semantics with no interlock cycles. The whole register file and the result register are brought out so that the architectural state can be observed.

Top module: `bypass_alu_pipe`

## Requirements
- R1: A synchronous active-high reset clears the result register, the operand latches and every register file entry to zero. It also marks both the execute and the write-back stage as stalled, so nothing is written in the two cycles after reset.
- R2: Operation code 1 produces the bitwise OR of the two operands. Operation code 0 produces the bitwise NOR.
- R3: An instruction sampled at clock edge k that is not stalled loads its ALU value into `result_q` at edge k+1. If the instruction is stalled, `result_q` keeps its value at that edge.
- R4: A non-stalled instruction sampled at edge k writes its value into the destination entry at edge k+2. Entry n appears on `regs_obs[n*D +: D]`, and register addresses are plain unsigned binary.
- R5: A stalled instruction leaves every register file entry unchanged.
- R6: An operand whose source equals the destination of the immediately preceding non-stalled instruction takes that instruction's result.
- R7: An operand whose source equals the destination of the non-stalled instruction two slots earlier takes that instruction's result, unless R8 applies.
- R8: When both earlier in-flight instructions target the operand's source and the newer one is not stalled, the newer result is used.
- R9: A stalled in-flight instruction is never forwarded. The operand sees the value that the register held before that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_stall | input | 1 | Stall flag of the instruction accepted this cycle |
| in_op | input | 1 | Operation code: 1 = OR, 0 = NOR |
| in_src_a | input | AW | First source register address |
| in_src_b | input | AW | Second source register address |
| in_dst | input | AW | Destination register address |
| result_q | output | D | Result register (execute stage output) |
| regs_obs | output | 2^AW*D | All register file entries, entry n at bits n*D +: D |

## Verification
The bench builds the block with its default parameters, AW=2 and D=8. With four registers, random addresses collide often, so execute forwarding, write-back forwarding and the case where both apply at once all occur many times in a few hundred instructions. Because every entry resets to zero, the values stay all-zeros or all-ones. Each forwarding error therefore turns a whole byte over and cannot hide. With a small register file, a bench model can compare the complete file in every cycle.

// File: rtl/bap_pkg.sv
package bap_pkg;
   typedef enum logic {
      OPC_NOR = 1'b0,
      OPC_OR  = 1'b1
   } bap_opc_e;
endpackage

// File: rtl/bap_alu.sv
module bap_alu
   import bap_pkg::*;
#(
   parameter int DW = 8
) (
   input  bap_opc_e          opc,
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   output logic [DW-1:0]     y
);
   logic [DW-1:0] any_set;

   assign any_set = a | b;

   always_comb begin
      unique case (opc)
         OPC_OR:  y = any_set;
         default: y = ~any_set;
      endcase
   end

   // R2: output relation against inputs, checked per evaluation
   always_comb begin
      if (opc == OPC_OR) a_r2_or_mode : assert (y == (a | b) || $isunknown(a) || $isunknown(b));
   end
endmodule

// File: rtl/bap_regfile.sv
module bap_regfile #(
   parameter int AW = 2,
   parameter int DW = 8,
   localparam int NREG = 1 << AW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [DW-1:0]       wr_data,
   output logic [NREG*DW-1:0]  flat_q
);
   logic [DW-1:0] mem [NREG];

   for (genvar n = 0; n < NREG; n++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            mem[n] <= '0;
         else if (wr_en && (wr_addr == AW'(n)))
            mem[n] <= wr_data;
      end
      assign flat_q[n*DW +: DW] = mem[n];
   end

   // R5: no enabled write, no change anywhere in the file
   a_r5_hold_when_stalled : assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(flat_q));

   // R4: enabled write lands in the addressed entry
   a_r4_write_lands : assert property (@(posedge clk) disable iff (rst)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/bap_opsel.sv
module bap_opsel #(
   parameter int AW = 2,
   parameter int DW = 8,
   localparam int NREG = 1 << AW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [AW-1:0]       src,
   input  logic                ex_live,
   input  logic [AW-1:0]       ex_dst,
   input  logic [DW-1:0]       ex_val,
   input  logic                wb_live,
   input  logic [AW-1:0]       wb_dst,
   input  logic [DW-1:0]       wb_val,
   input  logic [NREG*DW-1:0]  rf_flat,
   output logic [DW-1:0]       opnd_q
);
   logic [DW-1:0] rf_val;
   logic [DW-1:0] opnd_d;
   logic          hit_ex;
   logic          hit_wb;

   assign rf_val = rf_flat[src*DW +: DW];
   assign hit_ex = ex_live && (ex_dst == src);
   assign hit_wb = wb_live && (wb_dst == src);

   // newer producer first, then the one in write-back, then the file
   always_comb begin
      if (hit_ex)      opnd_d = ex_val;
      else if (hit_wb) opnd_d = wb_val;
      else             opnd_d = rf_val;
   end

   always_ff @(posedge clk) begin
      if (rst) opnd_q <= '0;
      else     opnd_q <= opnd_d;
   end

   // R6 / R8: execute-stage producer wins
   a_r6_exec_forward : assert property (@(posedge clk) disable iff (rst)
      (ex_live && ex_dst == src) |=> opnd_q == $past(ex_val));

   // R7: write-back producer used when execute does not match
   a_r7_wb_forward : assert property (@(posedge clk) disable iff (rst)
      (!(ex_live && ex_dst == src) && wb_live && wb_dst == src) |=> opnd_q == $past(wb_val));
endmodule

// File: rtl/bypass_alu_pipe.sv
module bypass_alu_pipe
   import bap_pkg::*;
#(
   parameter int AW = 2,
   parameter int DW = 8,
   localparam int NREG = 1 << AW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_stall,
   input  logic                in_op,
   input  logic [AW-1:0]       in_src_a,
   input  logic [AW-1:0]       in_src_b,
   input  logic [AW-1:0]       in_dst,
   output logic [DW-1:0]       result_q,
   output logic [NREG*DW-1:0]  regs_obs
);
   localparam int NPORT = 2;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("bypass_alu_pipe: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("bypass_alu_pipe: DW must be positive");
   end

   // execute / write-back side-band
   logic          stall_ex, stall_wb;
   logic [AW-1:0] dst_ex, dst_wb;
   bap_opc_e      opc_ex;
   logic [DW-1:0] alu_y;
   logic [DW-1:0] rf_wdata_unused_guard;

   logic [AW-1:0] src_v  [NPORT];
   logic [DW-1:0] opnd_v [NPORT];

   assign src_v[0] = in_src_a;
   assign src_v[1] = in_src_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         stall_ex <= 1'b1;
         stall_wb <= 1'b1;
         dst_ex   <= '0;
         dst_wb   <= '0;
         opc_ex   <= OPC_NOR;
      end else begin
         stall_ex <= in_stall;
         stall_wb <= stall_ex;
         dst_ex   <= in_dst;
         dst_wb   <= dst_ex;
         opc_ex   <= bap_opc_e'(in_op);
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      bap_opsel #(.AW(AW), .DW(DW)) u_sel (
         .clk     (clk),
         .rst     (rst),
         .src     (src_v[p]),
         .ex_live (!stall_ex),
         .ex_dst  (dst_ex),
         .ex_val  (alu_y),
         .wb_live (!stall_wb),
         .wb_dst  (dst_wb),
         .wb_val  (result_q),
         .rf_flat (regs_obs),
         .opnd_q  (opnd_v[p])
      );
   end

   bap_alu #(.DW(DW)) u_alu (
      .opc (opc_ex),
      .a   (opnd_v[0]),
      .b   (opnd_v[1]),
      .y   (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst)            result_q <= '0;
      else if (!stall_ex) result_q <= alu_y;
   end

   assign rf_wdata_unused_guard = result_q;

   bap_regfile #(.AW(AW), .DW(DW)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (!stall_wb),
      .wr_addr (dst_wb),
      .wr_data (rf_wdata_unused_guard),
      .flat_q  (regs_obs)
   );

   // R3: result register holds across a stalled execute slot
   a_r3_result_hold : assert property (@(posedge clk) disable iff (rst)
      stall_ex |=> $stable(result_q));

   // R3: result register takes the ALU value otherwise
   a_r3_result_load : assert property (@(posedge clk) disable iff (rst)
      !stall_ex |=> result_q == $past(alu_y));

   // R1: the cycle after reset, both later stages count as stalled, so the file is still clear
   a_r1_quiet_after_reset : assert property (@(posedge clk)
      $past(rst) |-> (regs_obs == '0));
endmodule

// File: tb/bypass_alu_pipe_test.sv
module bypass_alu_pipe_test;
   localparam int AW = 2;
   localparam int DW = 8;
   localparam int NREG = 1 << AW;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                in_stall = 1'b1;
   logic                in_op = 1'b0;
   logic [AW-1:0]       in_src_a = '0;
   logic [AW-1:0]       in_src_b = '0;
   logic [AW-1:0]       in_dst = '0;
   logic [DW-1:0]       result_q;
   logic [NREG*DW-1:0]  regs_obs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] model [NREG];
   logic [DW-1:0] s0 [NREG];
   logic [DW-1:0] s1 [NREG];
   logic [DW-1:0] s2 [NREG];
   logic [DW-1:0] exp_res;
   logic [DW-1:0] pend_v;
   bit            pend_stall;

   bypass_alu_pipe #(.AW(AW), .DW(DW)) uut (
      .clk      (clk),
      .rst      (rst),
      .in_stall (in_stall),
      .in_op    (in_op),
      .in_src_a (in_src_a),
      .in_src_b (in_src_b),
      .in_dst   (in_dst),
      .result_q (result_q),
      .regs_obs (regs_obs)
   );

   always #10 clk = ~clk;

   task automatic compare(input string tag, input string what,
                          input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_file(input string tag);
      int bad = -1;
      checks++;
      for (int n = 0; n < NREG; n++)
         if (bad < 0 && regs_obs[n*DW +: DW] !== s2[n]) bad = n;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s reg%0d: actual %h expected %h", tag, bad,
                  regs_obs[bad*DW +: DW], s2[bad]);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_stall = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int n = 0; n < NREG; n++) begin
         model[n] = '0; s0[n] = '0; s1[n] = '0; s2[n] = '0;
      end
      exp_res = '0;
      pend_v = '0;
      pend_stall = 1'b1;
   endtask

   // drive one instruction at a falling edge, check state after the next rising edge
   task automatic issue(input bit st, input bit op, input int a, input int b,
                        input int d, input string tag);
      logic [DW-1:0] v;
      v = op ? (model[a] | model[b]) : ~(model[a] | model[b]);
      in_stall = st;
      in_op    = op;
      in_src_a = AW'(a);
      in_src_b = AW'(b);
      in_dst   = AW'(d);
      @(posedge clk);
      if (!pend_stall) exp_res = pend_v;
      pend_v = v;
      pend_stall = st;
      s2 = s1;
      s1 = s0;
      if (!st) model[d] = v;
      s0 = model;
      @(negedge clk);
      compare(tag, "result_q", result_q, exp_res);
      check_file(tag);
   endtask

   task automatic drain(input string tag);
      issue(1'b1, 1'b0, 0, 0, 0, tag);
      issue(1'b1, 1'b0, 0, 0, 0, tag);
   endtask

   task automatic expect_reg(input int n, input logic [DW-1:0] v, input string tag);
      compare(tag, $sformatf("reg%0d", n), regs_obs[n*DW +: DW], v);
   endtask

   task automatic t_reset();
      do_reset();
      compare("R1", "result_q after reset", result_q, '0);
      for (int n = 0; n < NREG; n++) expect_reg(n, '0, "R1");
      issue(1'b1, 1'b0, 0, 0, 3, "R1");
      expect_reg(3, '0, "R1");
   endtask

   task automatic t_ops();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 1, "R2");   // NOR(0,0) -> FF
      issue(1'b0, 1'b1, 0, 0, 2, "R2");   // OR(0,0)  -> 00
      issue(1'b0, 1'b1, 0, 1, 3, "R2");   // OR(0,FF) -> FF
      drain("R2");
      expect_reg(1, 8'hFF, "R2");
      expect_reg(2, 8'h00, "R2");
      expect_reg(3, 8'hFF, "R2");
      compare("R3", "result_q last", result_q, 8'hFF);
   endtask

   task automatic t_exec_fwd();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 1, "R6");
      issue(1'b0, 1'b1, 1, 1, 2, "R6");   // needs r1 from execute
      drain("R6");
      expect_reg(2, 8'hFF, "R6");
   endtask

   task automatic t_wb_fwd();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 1, "R7");
      issue(1'b1, 1'b0, 0, 0, 0, "R7");   // bubble
      issue(1'b0, 1'b0, 1, 1, 2, "R7");   // r1 in write-back: NOR(FF) = 00
      issue(1'b0, 1'b1, 1, 0, 3, "R4");   // r1 now in file: FF
      drain("R7");
      expect_reg(2, 8'h00, "R7");
      expect_reg(3, 8'hFF, "R4");
   endtask

   task automatic t_priority();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 1, "R8");   // r1 = FF
      issue(1'b0, 1'b0, 1, 1, 1, "R8");   // r1 = 00
      issue(1'b0, 1'b1, 1, 1, 2, "R8");   // r2 = newer r1 = 00
      drain("R8");
      expect_reg(1, 8'h00, "R8");
      expect_reg(2, 8'h00, "R8");
   endtask

   task automatic t_stall_fwd();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 1, "R9");   // r1 = FF
      drain("R9");
      issue(1'b1, 1'b0, 1, 1, 1, "R9");   // stalled, would give 00
      issue(1'b0, 1'b1, 1, 1, 2, "R9");   // must see FF
      issue(1'b1, 1'b0, 1, 1, 1, "R9");   // stalled again
      issue(1'b1, 1'b0, 0, 0, 0, "R9");   // bubble, stalled one now in write-back
      issue(1'b0, 1'b1, 1, 1, 3, "R9");
      drain("R9");
      expect_reg(2, 8'hFF, "R9");
      expect_reg(3, 8'hFF, "R9");
   endtask

   task automatic t_stall_write();
      do_reset();
      issue(1'b0, 1'b0, 0, 0, 2, "R5");   // r2 = FF, result FF
      drain("R5");
      issue(1'b1, 1'b1, 0, 0, 2, "R5");   // stalled OR -> would be 00
      issue(1'b1, 1'b0, 2, 2, 0, "R5");
      drain("R5");
      expect_reg(2, 8'hFF, "R5");
      expect_reg(0, 8'h00, "R5");
      compare("R3", "result_q held", result_q, 8'hFF);
   endtask

   task automatic t_random();
      do_reset();
      for (int i = 0; i < 400; i++) begin
         issue(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, NREG-1)), int'($urandom_range(0, NREG-1)),
               int'($urandom_range(0, NREG-1)), "R4");
      end
      drain("R4");
   endtask

   initial begin
      t_reset();
      t_ops();
      t_exec_fwd();
      t_wb_fwd();
      t_priority();
      t_stall_fwd();
      t_stall_write();
      t_random();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule